// File: doc/BRIEF.md
# Parallel Single-Ramp Wilkinson Digitizer

This block converts a whole row of stored analog cell voltages at once. A single counter drives the code of a shared ramp DAC, and each cell's analog comparator trips when the ramp passes that cell's stored voltage. Each comparator reaches the block as one digital input bit per cell. Each cell owns a latch that records the counter value when its comparator first rises. The result is a full row of conversions in one ramp sweep, with only one counter and one latch per cell.

A start pulse clears the counter and begins the sweep. The counter and the ramp code rise by one on every clock from zero to the full-scale value. When the sweep ends, the block pulses `done` and streams the latched codes to the host, one cell per clock in ascending cell order, each marked by `out_valid`. The comparator bits pass through a two-flop synchronizer before edge detection. A latched code is therefore the counter value two clocks after the comparator input rises.

Top module: `wilk_ramp_adc`

## Requirements
- R1: After reset `busy`, `done` and `out_valid` are low and `ramp_code` is 0.
- R2: A start pulse accepted while idle sets `busy` in the next cycle, with `ramp_code` = 0. `ramp_code` then rises by exactly 1 per clock up to 2^CW-1 (4095 by default), and `busy` falls after the clock that ends that cycle.
- R3: When a cell's comparator bit is first driven high in the cycle where `ramp_code` = k, that cell reports code k+2. This is the counter value once the two-flop synchronizer has been crossed.
- R4: Only the first rising edge of a cell's comparator during a sweep is captured. Later falls and rises leave that cell's code unchanged.
- R5: A cell with no captured rising edge during the sweep reports 2^CW-1. This includes a cell whose crossing arrives too late to be seen before the sweep ends.
- R6: `done` is high for exactly one cycle. That cycle is the first cycle of shift-out.
- R7: During shift-out `out_valid` is high for NCELL consecutive cycles. `out_cell` runs 0,1,…,NCELL-1, and `out_code` carries that cell's code.
- R8: A start pulse while `busy` is high does not restart or disturb the sweep.
- R9: A start pulse during shift-out does not disturb the stream, and no new sweep follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| cmp_in | input | NCELL | Per-cell comparator outputs, asynchronous |
| ramp_code | output | CW | Code to the ramp DAC, equal to the shared counter |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| out_valid | output | 1 | Serial output word valid |
| out_cell | output | $clog2(NCELL) | Cell index of the output word |
| out_code | output | CW | Latched code of that cell |

## Verification
Every cycle, the assertions check the one-step rise of the ramp during a sweep and the holding of a captured code. They also check that `done` is a single pulse, that output indices increase strictly, and that a start pulse during a sweep or shift-out is refused. The exact code reported for a given crossing level can only be shown by the bench scenarios. The same holds for full-scale reporting of silent or late cells, for ignoring later comparator toggles, and for the order and content of the serial stream. The bench drives comparators from the observed ramp, like analog cells with known voltages, and scores every streamed word.

// File: rtl/wilk_ramp_adc.sv
module wilk_ramp_adc #(
  parameter int NCELL = 8,
  parameter int CW    = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NCELL-1:0]         cmp_in,
  output logic [CW-1:0]            ramp_code,
  output logic                     busy,
  output logic                     done,
  output logic                     out_valid,
  output logic [$clog2(NCELL)-1:0] out_cell,
  output logic [CW-1:0]            out_code
);
  localparam int IW = $clog2(NCELL);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};
  localparam logic [IW-1:0] LAST = IW'(NCELL-1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_SHIFT} state_t;
  state_t state;

  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [NCELL-1:0] s1, s2, s3, hit;
  logic [CW-1:0]    lat [NCELL];

  wire [NCELL-1:0] rise = s2 & ~s3;

  assign ramp_code = cnt;
  assign busy      = (state == S_CONV);
  assign out_valid = (state == S_SHIFT);
  assign out_cell  = idx;
  assign out_code  = lat[idx];

  always_ff @(posedge clk) begin
    s1 <= cmp_in;
    s2 <= s1;
    s3 <= s2;
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      done  <= 1'b0;
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_CONV;
          cnt   <= '0;
        end
        S_CONV: if (cnt == FULL) begin
          state <= S_SHIFT;
          idx   <= '0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_SHIFT: begin
          if (idx == LAST) state <= S_IDLE;
          else             idx   <= idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hit[i] <= 1'b0;
        lat[i] <= FULL;
      end else if (state == S_IDLE && start) begin
        hit[i] <= 1'b0;
        lat[i] <= FULL;
      end else if (state == S_CONV && rise[i] && !hit[i]) begin
        hit[i] <= 1'b1;
        lat[i] <= cnt;
      end
    end

    p_hold_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && state != S_IDLE) |=> $stable(lat[i]));
  end

  p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ramp_code != FULL) |=> (busy && ramp_code == $past(ramp_code) + 1'b1));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && out_cell == '0) ##1 !done);

  p_cell_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cell != LAST) |=> (out_valid && out_cell == $past(out_cell) + 1'b1));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ramp_code != '0);

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start) |=> !busy);
endmodule

// File: tb/wilk_ramp_adc_tb.sv
module wilk_ramp_adc_tb;
  localparam int NCELL = 8;
  localparam int CW    = 12;
  localparam int FULL  = (1 << CW) - 1;
  localparam int IW    = $clog2(NCELL);

  logic clk = 0, rst_n = 0, start = 0;
  logic [NCELL-1:0] cmp_in = '0;
  logic [CW-1:0] ramp_code, out_code;
  logic busy, done, out_valid;
  logic [IW-1:0] out_cell;

  always #2.5 clk = ~clk;

  wilk_ramp_adc #(.NCELL(NCELL), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .ramp_code(ramp_code), .busy(busy), .done(done), .out_valid(out_valid),
    .out_cell(out_cell), .out_code(out_code));

  int checks = 0, failures = 0;
  int th_up [NCELL], th_dn [NCELL], th_up2 [NCELL];
  int exp_q [$];
  int exp_idx = 0;
  bit seen_done = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // analog cell model: comparator follows the observed ramp level
  always @(negedge clk)
    for (int i = 0; i < NCELL; i++)
      cmp_in[i] <= busy && ((ramp_code >= th_up[i] && ramp_code < th_dn[i]) ||
                            ramp_code >= th_up2[i]);

  // monitor / scoreboard
  always @(negedge clk) begin
    if (done) begin
      chk(out_valid && out_cell == 0, "R6 done with first word", out_cell, 0);
      seen_done = 1;
    end
    if (out_valid) begin
      int e;
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected word", out_code, -1);
      end else begin
        e = exp_q.pop_front();
        chk(out_cell == exp_idx, "R7 cell order", out_cell, exp_idx);
        chk(out_code == e, "R3/R4/R5 code", out_code, e);
        exp_idx++;
      end
    end
  end

  task automatic set_cell(int i, int up, int dn = 1 << 20, int up2 = 1 << 20);
    th_up[i] = up; th_dn[i] = dn; th_up2[i] = up2;
  endtask

  task automatic run_conv(bit poke_conv, bit poke_shift);
    int prev;
    bit ramp_ok = 1;
    for (int i = 0; i < NCELL; i++) begin
      int first = (th_up[i] < th_up2[i]) ? th_up[i] : th_up2[i];
      exp_q.push_back((first + 2 > FULL) ? FULL : first + 2);
    end
    exp_idx = 0; seen_done = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && ramp_code == 0, "R2 sweep begins at 0", ramp_code, 0);
    prev = ramp_code;
    while (busy) begin
      if (poke_conv && prev == 1000) start = 1;
      @(negedge clk);
      start = 0;
      if (busy && ramp_code != prev + 1) ramp_ok = 0;
      if (busy) prev = ramp_code;
    end
    chk(ramp_ok, "R2/R8 ramp step by one", ramp_ok, 1);
    chk(prev == FULL, "R2 ramp reaches full scale", prev, FULL);
    if (poke_shift) begin
      start = 1; @(negedge clk); start = 0;
    end
    while (out_valid) @(negedge clk);
    chk(!busy, "R9 no new sweep after shift", busy, 0);
    chk(seen_done, "R6 done seen", seen_done, 1);
    chk(exp_idx == NCELL, "R7 word count", exp_idx, NCELL);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NCELL; i++) set_cell(i, 1 << 20);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !out_valid && ramp_code == 0, "R1 reset state", ramp_code, 0);

    // distinct levels, including bottom and late crossings (R3, R5)
    for (int i = 0; i < NCELL; i++) set_cell(i, 300 * i + 17);
    set_cell(0, 0);
    set_cell(5, 4093);
    set_cell(6, 4094);
    set_cell(7, 1 << 20);
    run_conv(0, 0);

    // later toggles ignored (R4), start during sweep and shift ignored (R8, R9)
    for (int i = 0; i < NCELL; i++) set_cell(i, 4000 - 500 * i);
    set_cell(2, 100, 110, 900);
    set_cell(4, 2000, 2003, 2010);
    set_cell(3, 1 << 20, 1 << 20, 1500);
    run_conv(1, 1);

    // all cells silent (R5)
    for (int i = 0; i < NCELL; i++) set_cell(i, 1 << 20);
    run_conv(0, 0);

    // all cells at one level (R3)
    for (int i = 0; i < NCELL; i++) set_cell(i, 2222);
    run_conv(0, 0);

    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule